// File: doc/BRIEF.md
# Interlaced Field Parity Detector

This block tells the two fields of an interlaced picture apart by measuring where the vertical sync edge lands inside a horizontal line. A 7-bit phase counter is cleared by every horizontal sync. It advances once every three system clocks. At each vertical sync leading edge, the top four bits of that counter are captured. Successive captures alternate between two 4-bit holding slots, A and B. Because the two fields of an interlaced frame place their vertical sync roughly half a line apart, the two slots end up holding different phases. Comparing the slots therefore reveals which field just began.

A comparator raises a field-match flag for the display start field. A select input chooses which of the two fields that is. Both slots are readable through an 8-bit status word. A next-slot indicator names the slot that the coming vertical sync will load. The display controller that acts on the flag and any register access path sit outside this block.

Top module: `field_parity_detector`

## Requirements
- R1: A synchronous active-high reset clears the status word, the next-slot indicator and the field-match flag to 0.
- R2: Each leading edge of HSYNC clears the phase counter and the divide-by-3 prescaler. The counter then advances once every three clocks. When HSYNC rises D clocks before VSYNC rises (both applied at the ports), the captured phase is min(127, floor((D-1)/3)).
- R3: A capture stores only bits 6:3 of the 7-bit phase counter. The low three bits are discarded.
- R4: Slot A is status bits 3:0 and slot B is status bits 7:4. The first capture after reset goes to slot A, and later captures alternate A, B, A, B. The slot not being loaded keeps its value.
- R5: The next-slot output is 0 when slot A receives the next capture and 1 when slot B does. It inverts on every VSYNC leading edge.
- R6: One clock after each capture, the field-match flag becomes (A > B) XOR start_sel, with A and B treated as unsigned. When A equals B, the flag equals start_sel.
- R7: If HSYNC stops arriving, the phase counter holds at 127 and does not wrap.
- R8: A VSYNC held high for many clocks causes exactly one capture.
- R9: A change of start_sel has no effect on the field-match flag until the next capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| hsync_in | input | 1 | Horizontal sync, asynchronous, active high |
| vsync_in | input | 1 | Vertical sync, asynchronous, active high |
| start_sel | input | 1 | Selects which field raises the match flag |
| status_o | output | 8 | {slot B, slot A} captured phases |
| next_slot_o | output | 1 | 0: slot A loads next, 1: slot B loads next |
| field_match_o | output | 1 | High in the chosen display start field |

## Verification
Randomly chosen HSYNC-to-VSYNC distances across the whole line exercise the prescaler and the bit selection. Distances that differ only in the discarded low counter bits must give equal slots, while distances straddling a multiple of 24 clocks must give different slots. Captured pairs with A above, below and equal to B, under both select values, separate the comparison direction from the equality case. A very long distance exposes wrap-around, a long VSYNC pulse exposes double capture, and toggling the select between captures shows whether the flag is combinational or registered.

// File: rtl/field_parity_detector.sv
module field_parity_detector #(
  parameter int CNT_W = 7,
  parameter int CAP_W = 4,
  parameter int DIV   = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               hsync_in,
  input  logic               vsync_in,
  input  logic               start_sel,
  output logic [2*CAP_W-1:0] status_o,
  output logic               next_slot_o,
  output logic               field_match_o
);
  localparam int DIV_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV - 1);

  logic [2:0] hs_pipe, vs_pipe;
  logic       hs_rise, vs_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_pipe <= '0;
      vs_pipe <= '0;
    end else begin
      hs_pipe <= {hs_pipe[1:0], hsync_in};
      vs_pipe <= {vs_pipe[1:0], vsync_in};
    end
  end

  assign hs_rise = hs_pipe[1] & ~hs_pipe[2];
  assign vs_rise = vs_pipe[1] & ~vs_pipe[2];

  logic [DIV_W-1:0] div_q;
  logic [CNT_W-1:0] phase_q;
  wire              tick = (div_q == DIV_LAST);

  always_ff @(posedge clk) begin
    if (rst || hs_rise) begin
      div_q   <= '0;
      phase_q <= '0;
    end else begin
      div_q <= tick ? '0 : div_q + DIV_W'(1);
      if (tick && phase_q != CNT_MAX) phase_q <= phase_q + CNT_W'(1);
    end
  end

  logic [CAP_W-1:0] slot_a, slot_b;
  logic             sel_b, cap_d, match_q;
  wire  [CAP_W-1:0] top_bits = phase_q[CNT_W-1 -: CAP_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_a  <= '0;
      slot_b  <= '0;
      sel_b   <= 1'b0;
      cap_d   <= 1'b0;
      match_q <= 1'b0;
    end else begin
      cap_d <= vs_rise;
      if (vs_rise) begin
        if (sel_b) slot_b <= top_bits;
        else       slot_a <= top_bits;
        sel_b <= ~sel_b;
      end
      if (cap_d) match_q <= (slot_a > slot_b) ^ start_sel;
    end
  end

  assign status_o      = {slot_b, slot_a};
  assign next_slot_o   = sel_b;
  assign field_match_o = match_q;

  a_r2_clear: assert property (@(posedge clk) disable iff (rst)
    hs_rise |=> phase_q == '0);
  a_r2_step: assert property (@(posedge clk) disable iff (rst)
    !hs_rise && !$past(hs_rise) |=>
      (phase_q == $past(phase_q)) || (phase_q == $past(phase_q) + CNT_W'(1)));
  a_r7_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (phase_q == CNT_MAX) && !hs_rise |=> phase_q == CNT_MAX);
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    !vs_rise |=> $stable(slot_a) && $stable(slot_b));
  a_r4_one_slot: assert property (@(posedge clk) disable iff (rst)
    vs_rise |=> $stable(slot_a) || $stable(slot_b));
  a_r5_flip: assert property (@(posedge clk) disable iff (rst)
    vs_rise |=> next_slot_o != $past(next_slot_o));
  a_r8_single: assert property (@(posedge clk) disable iff (rst)
    vs_rise |=> !vs_rise);
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !cap_d |=> $stable(field_match_o));
endmodule

// File: tb/field_parity_detector_test.sv
`timescale 1ns/1ps
module field_parity_detector_test;
  logic clk = 1'b0, rst = 1'b1, hs = 1'b0, vs = 1'b0, sel = 1'b0;
  logic [7:0] status;
  logic       nxt, match;
  int checks = 0, failures = 0;
  int exp_a = 0, exp_b = 0, exp_nxt = 0, exp_match = 0;

  always #4 clk = ~clk;

  field_parity_detector uut (
    .clk(clk), .rst(rst), .hsync_in(hs), .vsync_in(vs), .start_sel(sel),
    .status_o(status), .next_slot_o(nxt), .field_match_o(match));

  function automatic int phase_of(int d);
    int p = (d - 1) / 3;
    if (p > 127) p = 127;
    return p >> 3;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_all(string req);
    chk({req, " slotA"}, int'(status[3:0]), exp_a);
    chk({req, " slotB"}, int'(status[7:4]), exp_b);
    chk({req, " next"}, int'(nxt), exp_nxt);
    chk({req, " match"}, int'(match), exp_match);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; hs = 1'b0; vs = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    exp_a = 0; exp_b = 0; exp_nxt = 0; exp_match = 0;
  endtask

  task automatic do_field(int d, int vs_len);
    int p = phase_of(d);
    @(negedge clk); hs = 1'b1;
    for (int i = 0; i < d; i++) begin
      @(negedge clk); hs = 1'b0;
    end
    vs = 1'b1;
    for (int i = 0; i < vs_len; i++) @(negedge clk);
    vs = 1'b0;
    repeat (4) @(negedge clk);
    if (exp_nxt == 0) exp_a = p; else exp_b = p;
    exp_nxt = 1 - exp_nxt;
    exp_match = ((exp_a > exp_b) ? 1 : 0) ^ int'(sel);
  endtask

  task automatic run_all();
    // R1: reset state
    do_reset();
    check_all("R1");
    // R2/R3/R4/R5/R6: directed fields, A gets 1st, B gets 2nd
    do_field(49, 2);      // (48/3)=16 -> 2
    check_all("R4 first capture R2");
    do_field(145, 2);     // 48 -> 6
    check_all("R4 second capture R6");
    // R3: 73 -> 24 -> 3 and 94 -> 31 -> 3 land in the same slot value
    do_field(73, 2);
    check_all("R3 low bits");
    do_field(94, 2);
    check_all("R3 equal slots R6");
    sel = 1'b1;
    do_field(94, 2);
    check_all("R6 equal with sel");
    // R7: very long line saturates at 127 -> 15
    do_field(600, 2);
    check_all("R7 saturate");
    chk("R7 top nibble", int'(status[7:4]), 15);
    // R8: long VSYNC gives one capture
    do_field(10, 40);
    check_all("R8 single capture");
    // R9: select change without capture
    sel = ~sel;
    repeat (6) @(negedge clk);
    chk("R9 match held", int'(match), exp_match);
    exp_match = ((exp_a > exp_b) ? 1 : 0) ^ int'(sel);
    // R1: reset mid-run clears everything
    do_reset();
    check_all("R1 re-reset");
    // random fields across the line
    void'($urandom(32'd2024));
    for (int k = 0; k < 40; k++) begin
      int d = 1 + int'($urandom_range(0, 420));
      if ($urandom_range(0, 3) == 0) sel = ~sel;
      do_field(d, 1 + int'($urandom_range(0, 5)));
      check_all("R2 R4 R5 R6 random");
    end
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule